// File: doc/BRIEF.md
# Maintenance Window Address Translator

This block sits between a simple CPU load/store port and the request side of a serial-fabric endpoint. It turns a CPU access that falls inside a local 4 MiB maintenance window into one maintenance request descriptor. Before the access, software loads a translation register. That register supplies the remote destination ID, the hop count and the upper part of the remote configuration offset. The low window address bits supply the rest of the offset. The CPU access stalls until the fabric takes a write or returns read data. Read data is extracted from a big-endian word image.

A 4 KiB doorbell window lies directly above the maintenance window. A CPU write there sends a doorbell request that carries a 16-bit info value to the destination held in the doorbell translation register. Each window has its own enable bit. An access that misses both windows, or that hits a disabled window, completes locally: reads return all-ones and writes are dropped.

Top module: `maint_window_xlate`

## Requirements
- R1: After reset, `cpu_ready` and `fab_req_valid` are low and both windows are disabled, so a read anywhere returns 0xFFFFFFFF without a fabric request.
- R2: A write with `cfg_sel`=0 loads the maintenance translation register. Bits [31:22] are the destination ID, bits [19:12] the hop count and bits [11:0] the upper offset. Bits [21:20] are ignored. `cfg_sel`=2 loads the doorbell translation register, whose bits [31:22] are the doorbell destination ID.
- R3: A maintenance request carries the loaded destination ID and hop count. Its 21-bit offset is {upper offset, cpu_addr[8:0]}. Window address bits [21:9] do not reach the offset.
- R4: The maintenance window covers WIN_BASE to WIN_BASE+0x3FFFFF. The doorbell window covers the next 0x1000 bytes. Any other address completes locally.
- R5: `cpu_size` encodes 0 = byte, 1 = halfword, 2 = word, and 3 is treated as a word. The request size uses the same 0/1/2 code. Write data arrives right-justified on `cpu_wdata` and is placed big-endian in the request word: byte k = cpu_addr[1:0] goes to bits [31-8k:24-8k], a halfword at cpu_addr[1]=0 goes to bits [31:16] and at cpu_addr[1]=1 to bits [15:0], and a word goes unchanged.
- R6: A read returns the addressed byte or halfword from `fab_rsp_data`, using the same lane placement as R5, right-justified and zero-extended on `cpu_rdata`. A word read returns the whole response word.
- R7: A fabric request is held with a stable descriptor while `fab_req_ready` is low. `cpu_ready` pulses for exactly one cycle, in the cycle after a write is accepted. With s stall cycles, a write completes 2+s cycles after the request is presented.
- R8: A read waits for `fab_rsp_valid`, and `cpu_ready` pulses in the following cycle, so that a read completes 3+s cycles after the request is presented.
- R9: Bit 0 of the attribute registers (`cfg_sel`=1 for maintenance, 3 for doorbell) enables that window. While the window is disabled, a read returns 0xFFFFFFFF and a write sends no request. A local completion makes `cpu_ready` pulse one cycle after the request is presented.
- R10: A write to the doorbell window sends one request with `fab_req_doorbell`=1, the doorbell destination ID, hop 0, offset 0, size 1 and cpu_wdata[15:0] in `fab_req_wdata`[15:0], with the upper bits zero.
- R11: A read of the doorbell window completes locally with 0xFFFFFFFF and sends no request.
- R12: A translation register write made while a request is outstanding does not change that request's descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_sel | input | 2 | Register select: 0 maint target, 1 maint attr, 2 doorbell target, 3 doorbell attr |
| cfg_wdata | input | 32 | Configuration write data |
| cpu_req | input | 1 | CPU access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | CPU byte address |
| cpu_size | input | 2 | Access size code |
| cpu_wdata | input | 32 | Right-justified write data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Read data, valid with `cpu_ready` |
| fab_req_valid | output | 1 | Fabric request valid |
| fab_req_ready | input | 1 | Fabric accepts the request |
| fab_req_write | output | 1 | Request is a write |
| fab_req_doorbell | output | 1 | Request is a doorbell |
| fab_req_dest | output | DEST_W | Destination ID |
| fab_req_hop | output | HOP_W | Hop count |
| fab_req_ofs | output | OFS_W | Configuration offset |
| fab_req_size | output | 2 | Size code |
| fab_req_wdata | output | 32 | Big-endian lane-placed write data |
| fab_rsp_valid | input | 1 | Read response valid |
| fab_rsp_data | input | 32 | Read response word, big-endian |

## Verification
On every cycle, the assertions check that a request stays stable while it waits, that `cpu_ready` is a single-cycle pulse that never overlaps a pending request, that accepted writes and taken responses complete one cycle later, that local reads return all-ones, and that every doorbell request has the fixed shape. Only the bench scenarios can show how the offset is assembled from the register and the window address, how byte lanes are placed and extracted, where the window boundaries fall, what the enable bits do, and that a register write made mid-request has no effect, because each of these needs the stimulus to be known.

// File: rtl/mwt_pkg.sv
package mwt_pkg;

  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } size_e;

  typedef enum logic [1:0] {
    SEL_MT_TGT  = 2'd0,
    SEL_MT_ATTR = 2'd1,
    SEL_DB_TGT  = 2'd2,
    SEL_DB_ATTR = 2'd3
  } cfg_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_DONE
  } xstate_e;

  // Size code 3 collapses onto a word access.
  function automatic logic [1:0] norm_size(input logic [1:0] sz);
    return (sz == 2'd3) ? SZ_WORD : sz;
  endfunction

  // Right-justified CPU value -> big-endian lane position in a word.
  function automatic logic [DATA_W-1:0] lane_place(input logic [1:0] sz,
                                                   input logic [1:0] k,
                                                   input logic [DATA_W-1:0] v);
    logic [DATA_W-1:0] t;
    case (sz)
      SZ_BYTE: begin
        t = {24'b0, v[7:0]};
        return t << (8 * (3 - int'(k)));
      end
      SZ_HALF: begin
        t = {16'b0, v[15:0]};
        return k[1] ? t : (t << 16);
      end
      default: return v;
    endcase
  endfunction

  // Big-endian word image -> right-justified CPU value.
  function automatic logic [DATA_W-1:0] lane_pick(input logic [1:0] sz,
                                                  input logic [1:0] k,
                                                  input logic [DATA_W-1:0] w);
    logic [DATA_W-1:0] t;
    case (sz)
      SZ_BYTE: begin
        t = w >> (8 * (3 - int'(k)));
        return {24'b0, t[7:0]};
      end
      SZ_HALF: begin
        t = k[1] ? w : (w >> 16);
        return {16'b0, t[15:0]};
      end
      default: return w;
    endcase
  endfunction

endpackage

// File: rtl/mwt_regs.sv
module mwt_regs
  import mwt_pkg::*;
#(
  parameter int DEST_W   = 10,
  parameter int HOP_W    = 8,
  parameter int UPPER_W  = 12,
  parameter int DEST_LSB = 22,
  parameter int HOP_LSB  = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_sel,
  input  logic [DATA_W-1:0]  cfg_wdata,
  output logic [DEST_W-1:0]  mt_dest,
  output logic [HOP_W-1:0]   mt_hop,
  output logic [UPPER_W-1:0] mt_upper,
  output logic [DEST_W-1:0]  db_dest,
  output logic [1:0]         win_en
);

  localparam int NWIN = 2;

  logic unused_cfg;
  assign unused_cfg = ^cfg_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mt_dest  <= '0;
      mt_hop   <= '0;
      mt_upper <= '0;
      db_dest  <= '0;
    end else if (cfg_we) begin
      if (cfg_sel == SEL_MT_TGT) begin
        mt_dest  <= cfg_wdata[DEST_LSB +: DEST_W];
        mt_hop   <= cfg_wdata[HOP_LSB +: HOP_W];
        mt_upper <= cfg_wdata[UPPER_W-1:0];
      end
      if (cfg_sel == SEL_DB_TGT) begin
        db_dest <= cfg_wdata[DEST_LSB +: DEST_W];
      end
    end
  end

  // One enable flop per window; window w owns select code {w, 1}.
  for (genvar w = 0; w < NWIN; w++) begin : g_en
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        win_en[w] <= 1'b0;
      end else if (cfg_we && cfg_sel == {w[0], 1'b1}) begin
        win_en[w] <= cfg_wdata[0];
      end
    end
  end

endmodule

// File: rtl/mwt_decode.sv
module mwt_decode
  import mwt_pkg::*;
#(
  parameter int              ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'h8000_0000,
  parameter int              MAINT_AW = 22,
  parameter int              DB_AW    = 12,
  parameter int              DEST_W   = 10,
  parameter int              HOP_W    = 8,
  parameter int              OFS_W    = 21,
  parameter int              SPLIT    = 9
) (
  input  logic [ADDR_W-1:0]        cpu_addr,
  input  logic                     cpu_we,
  input  logic [1:0]               cpu_size,
  input  logic [DATA_W-1:0]        cpu_wdata,
  input  logic [DEST_W-1:0]        mt_dest,
  input  logic [HOP_W-1:0]         mt_hop,
  input  logic [OFS_W-SPLIT-1:0]   mt_upper,
  input  logic [DEST_W-1:0]        db_dest,
  input  logic [1:0]               win_en,
  output logic                     go_fabric,
  output logic                     dsc_doorbell,
  output logic [DEST_W-1:0]        dsc_dest,
  output logic [HOP_W-1:0]         dsc_hop,
  output logic [OFS_W-1:0]         dsc_ofs,
  output logic [1:0]               dsc_size,
  output logic [DATA_W-1:0]        dsc_wdata,
  output logic [1:0]               dsc_lane
);

  localparam logic [ADDR_W-1:0] DB_BASE = WIN_BASE + (ADDR_W'(1) << MAINT_AW);

  logic in_maint, in_db;
  logic [1:0] sz;
  logic unused_addr;

  assign unused_addr = ^cpu_addr;
  assign in_maint = (cpu_addr[ADDR_W-1:MAINT_AW] == WIN_BASE[ADDR_W-1:MAINT_AW]);
  assign in_db    = (cpu_addr[ADDR_W-1:DB_AW] == DB_BASE[ADDR_W-1:DB_AW]);
  assign sz       = norm_size(cpu_size);

  always_comb begin
    go_fabric    = (in_maint && win_en[0]) || (in_db && win_en[1] && cpu_we);
    dsc_doorbell = in_db;
    dsc_lane     = cpu_addr[1:0];
    if (in_db) begin
      dsc_dest  = db_dest;
      dsc_hop   = '0;
      dsc_ofs   = '0;
      dsc_size  = SZ_HALF;
      dsc_wdata = {16'b0, cpu_wdata[15:0]};
    end else begin
      dsc_dest  = mt_dest;
      dsc_hop   = mt_hop;
      dsc_ofs   = {mt_upper, cpu_addr[SPLIT-1:0]};
      dsc_size  = sz;
      dsc_wdata = cpu_we ? lane_place(sz, cpu_addr[1:0], cpu_wdata) : '0;
    end
  end

endmodule

// File: rtl/mwt_ctrl.sv
module mwt_ctrl
  import mwt_pkg::*;
#(
  parameter int DEST_W = 10,
  parameter int HOP_W  = 8,
  parameter int OFS_W  = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic              go_fabric,
  input  logic              dsc_doorbell,
  input  logic [DEST_W-1:0] dsc_dest,
  input  logic [HOP_W-1:0]  dsc_hop,
  input  logic [OFS_W-1:0]  dsc_ofs,
  input  logic [1:0]        dsc_size,
  input  logic [DATA_W-1:0] dsc_wdata,
  input  logic [1:0]        dsc_lane,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              fab_req_valid,
  input  logic              fab_req_ready,
  output logic              fab_req_write,
  output logic              fab_req_doorbell,
  output logic [DEST_W-1:0] fab_req_dest,
  output logic [HOP_W-1:0]  fab_req_hop,
  output logic [OFS_W-1:0]  fab_req_ofs,
  output logic [1:0]        fab_req_size,
  output logic [DATA_W-1:0] fab_req_wdata,
  input  logic              fab_rsp_valid,
  input  logic [DATA_W-1:0] fab_rsp_data,
  output logic              acc_local_rd,
  output logic              rsp_take
);

  xstate_e    state;
  logic [1:0] lane_q;
  logic       start;

  assign start         = (state == ST_IDLE) && cpu_req;
  assign acc_local_rd  = start && !go_fabric && !cpu_we;
  assign rsp_take      = (state == ST_WAIT) && fab_rsp_valid;
  assign cpu_ready     = (state == ST_DONE);
  assign fab_req_valid = (state == ST_REQ);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state            <= ST_IDLE;
      cpu_rdata        <= '0;
      lane_q           <= '0;
      fab_req_write    <= 1'b0;
      fab_req_doorbell <= 1'b0;
      fab_req_dest     <= '0;
      fab_req_hop      <= '0;
      fab_req_ofs      <= '0;
      fab_req_size     <= '0;
      fab_req_wdata    <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (cpu_req) begin
            if (go_fabric) begin
              fab_req_write    <= cpu_we;
              fab_req_doorbell <= dsc_doorbell;
              fab_req_dest     <= dsc_dest;
              fab_req_hop      <= dsc_hop;
              fab_req_ofs      <= dsc_ofs;
              fab_req_size     <= dsc_size;
              fab_req_wdata    <= dsc_wdata;
              lane_q           <= dsc_lane;
              state            <= ST_REQ;
            end else begin
              cpu_rdata <= '1;
              state     <= ST_DONE;
            end
          end
        end
        ST_REQ: begin
          if (fab_req_ready) begin
            if (fab_req_write) begin
              cpu_rdata <= '0;
              state     <= ST_DONE;
            end else begin
              state <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (fab_rsp_valid) begin
            cpu_rdata <= lane_pick(fab_req_size, lane_q, fab_rsp_data);
            state     <= ST_DONE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/maint_window_xlate.sv
module maint_window_xlate
  import mwt_pkg::*;
#(
  parameter int                ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'h8000_0000,
  parameter int                MAINT_AW = 22,
  parameter int                DB_AW    = 12,
  parameter int                DEST_W   = 10,
  parameter int                HOP_W    = 8,
  parameter int                OFS_W    = 21,
  parameter int                SPLIT    = 9,
  parameter int                DEST_LSB = 22,
  parameter int                HOP_LSB  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [31:0]       cfg_wdata,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [1:0]        cpu_size,
  input  logic [31:0]       cpu_wdata,
  output logic              cpu_ready,
  output logic [31:0]       cpu_rdata,
  output logic              fab_req_valid,
  input  logic              fab_req_ready,
  output logic              fab_req_write,
  output logic              fab_req_doorbell,
  output logic [DEST_W-1:0] fab_req_dest,
  output logic [HOP_W-1:0]  fab_req_hop,
  output logic [OFS_W-1:0]  fab_req_ofs,
  output logic [1:0]        fab_req_size,
  output logic [31:0]       fab_req_wdata,
  input  logic              fab_rsp_valid,
  input  logic [31:0]       fab_rsp_data
);

  localparam int UPPER_W = OFS_W - SPLIT;

  logic [DEST_W-1:0]  mt_dest, db_dest, dsc_dest;
  logic [HOP_W-1:0]   mt_hop, dsc_hop;
  logic [UPPER_W-1:0] mt_upper;
  logic [1:0]         win_en;
  logic               go_fabric, dsc_doorbell;
  logic [OFS_W-1:0]   dsc_ofs;
  logic [1:0]         dsc_size, dsc_lane;
  logic [31:0]        dsc_wdata;
  logic               acc_local_rd, rsp_take;

  mwt_regs #(
    .DEST_W(DEST_W), .HOP_W(HOP_W), .UPPER_W(UPPER_W),
    .DEST_LSB(DEST_LSB), .HOP_LSB(HOP_LSB)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .mt_dest(mt_dest), .mt_hop(mt_hop),
    .mt_upper(mt_upper), .db_dest(db_dest), .win_en(win_en)
  );

  mwt_decode #(
    .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .MAINT_AW(MAINT_AW), .DB_AW(DB_AW),
    .DEST_W(DEST_W), .HOP_W(HOP_W), .OFS_W(OFS_W), .SPLIT(SPLIT)
  ) u_dec (
    .cpu_addr(cpu_addr), .cpu_we(cpu_we), .cpu_size(cpu_size),
    .cpu_wdata(cpu_wdata), .mt_dest(mt_dest), .mt_hop(mt_hop),
    .mt_upper(mt_upper), .db_dest(db_dest), .win_en(win_en),
    .go_fabric(go_fabric), .dsc_doorbell(dsc_doorbell), .dsc_dest(dsc_dest),
    .dsc_hop(dsc_hop), .dsc_ofs(dsc_ofs), .dsc_size(dsc_size),
    .dsc_wdata(dsc_wdata), .dsc_lane(dsc_lane)
  );

  mwt_ctrl #(
    .DEST_W(DEST_W), .HOP_W(HOP_W), .OFS_W(OFS_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .go_fabric(go_fabric), .dsc_doorbell(dsc_doorbell), .dsc_dest(dsc_dest),
    .dsc_hop(dsc_hop), .dsc_ofs(dsc_ofs), .dsc_size(dsc_size),
    .dsc_wdata(dsc_wdata), .dsc_lane(dsc_lane),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .fab_req_valid(fab_req_valid), .fab_req_ready(fab_req_ready),
    .fab_req_write(fab_req_write), .fab_req_doorbell(fab_req_doorbell),
    .fab_req_dest(fab_req_dest), .fab_req_hop(fab_req_hop),
    .fab_req_ofs(fab_req_ofs), .fab_req_size(fab_req_size),
    .fab_req_wdata(fab_req_wdata), .fab_rsp_valid(fab_rsp_valid),
    .fab_rsp_data(fab_rsp_data), .acc_local_rd(acc_local_rd),
    .rsp_take(rsp_take)
  );

endmodule

// File: rtl/maint_window_xlate_chk.sv
module maint_window_xlate_chk #(
  parameter int DEST_W = 10,
  parameter int HOP_W  = 8,
  parameter int OFS_W  = 21
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_ready,
  input logic [31:0]       cpu_rdata,
  input logic              fab_req_valid,
  input logic              fab_req_ready,
  input logic              fab_req_write,
  input logic              fab_req_doorbell,
  input logic [DEST_W-1:0] fab_req_dest,
  input logic [HOP_W-1:0]  fab_req_hop,
  input logic [OFS_W-1:0]  fab_req_ofs,
  input logic [1:0]        fab_req_size,
  input logic [31:0]       fab_req_wdata,
  input logic              acc_local_rd,
  input logic              rsp_take
);

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fab_req_valid && !fab_req_ready |=> fab_req_valid && $stable(fab_req_dest)
      && $stable(fab_req_hop) && $stable(fab_req_ofs) && $stable(fab_req_wdata)
      && $stable(fab_req_write) && $stable(fab_req_size));

  // R7
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready);

  // R7
  ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_ready && fab_req_valid));

  // R7
  write_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fab_req_valid && fab_req_ready && fab_req_write |=> cpu_ready);

  // R8
  rsp_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_take |=> cpu_ready);

  // R9
  local_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_local_rd |=> cpu_ready && cpu_rdata == 32'hFFFF_FFFF);

  // R10
  bell_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fab_req_valid && fab_req_doorbell |-> fab_req_write && fab_req_size == 2'd1
      && fab_req_hop == '0 && fab_req_ofs == '0 && fab_req_wdata[31:16] == 16'h0);

endmodule

bind maint_window_xlate maint_window_xlate_chk #(
  .DEST_W(DEST_W), .HOP_W(HOP_W), .OFS_W(OFS_W)
) u_chk (.*);

// File: tb/maint_window_xlate_test.sv
`timescale 1ns/1ps
module maint_window_xlate_test;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_we = 0;
  logic [1:0]  cfg_sel = 0;
  logic [31:0] cfg_wdata = 0;
  logic        cpu_req = 0, cpu_we = 0;
  logic [31:0] cpu_addr = 0;
  logic [1:0]  cpu_size = 0;
  logic [31:0] cpu_wdata = 0;
  logic        cpu_ready;
  logic [31:0] cpu_rdata;
  logic        fab_req_valid, fab_req_ready = 0;
  logic        fab_req_write, fab_req_doorbell;
  logic [9:0]  fab_req_dest;
  logic [7:0]  fab_req_hop;
  logic [20:0] fab_req_ofs;
  logic [1:0]  fab_req_size;
  logic [31:0] fab_req_wdata;
  logic        fab_rsp_valid = 0;
  logic [31:0] fab_rsp_data = 0;

  int checks = 0, errors = 0;

  bit          r_seen, r_write, r_db;
  logic [9:0]  r_dest;
  logic [7:0]  r_hop;
  logic [20:0] r_ofs;
  logic [1:0]  r_size;
  logic [31:0] r_wdata, r_rdata;
  int          r_cycles;

  always #2.5 clk = ~clk;

  maint_window_xlate uut (.*);

  typedef struct packed {
    logic        we;
    logic [31:0] addr;
    logic [1:0]  sz;
    logic [31:0] wd;
    logic [31:0] rsp;
    logic [20:0] ofs;
    logic [1:0]  esz;
    logic [31:0] ewd;
    logic [31:0] erd;
    logic [1:0]  stall;
  } vec_t;

  // Maint target: dest 0x2A5, hop 0x3C, upper 0xABC -> offset base 0x157800.
  localparam vec_t VECS [10] = '{
    '{1'b1, 32'h8000_0104, 2'd2, 32'h1122_3344, 32'h0, 21'h157904, 2'd2, 32'h1122_3344, 32'h0, 2'd0},
    '{1'b1, 32'h8000_0011, 2'd0, 32'h0000_00AB, 32'h0, 21'h157811, 2'd0, 32'h00AB_0000, 32'h0, 2'd1},
    '{1'b1, 32'h8000_0022, 2'd1, 32'h0000_BEEF, 32'h0, 21'h157822, 2'd1, 32'h0000_BEEF, 32'h0, 2'd2},
    '{1'b1, 32'h8000_01FF, 2'd0, 32'hFFFF_FF5A, 32'h0, 21'h1579FF, 2'd0, 32'h0000_005A, 32'h0, 2'd3},
    '{1'b1, 32'h8000_0008, 2'd3, 32'hDEAD_BEEF, 32'h0, 21'h157808, 2'd2, 32'hDEAD_BEEF, 32'h0, 2'd0},
    '{1'b0, 32'h8000_0040, 2'd2, 32'h0,         32'hCAFE_F00D, 21'h157840, 2'd2, 32'h0, 32'hCAFE_F00D, 2'd0},
    '{1'b0, 32'h8000_0080, 2'd0, 32'h0,         32'h1234_5678, 21'h157880, 2'd0, 32'h0, 32'h0000_0012, 2'd1},
    '{1'b0, 32'h8000_0082, 2'd0, 32'h0,         32'h1234_5678, 21'h157882, 2'd0, 32'h0, 32'h0000_0056, 2'd2},
    '{1'b0, 32'h8000_0100, 2'd1, 32'h0,         32'h1234_5678, 21'h157900, 2'd1, 32'h0, 32'h0000_1234, 2'd0},
    '{1'b0, 32'h803F_FE02, 2'd1, 32'h0,         32'h1234_5678, 21'h157802, 2'd1, 32'h0, 32'h0000_5678, 2'd3}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic run_access(input logic we, input logic [31:0] addr, input logic [1:0] sz,
                            input logic [31:0] wd, input logic [31:0] rsp,
                            input int stall, input bit poke);
    int  waited;
    bit  took;
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = addr; cpu_size = sz; cpu_wdata = wd;
    r_seen = 0; r_cycles = 0; waited = 0; took = 0; r_rdata = 'x;
    while (1) begin
      @(negedge clk);
      r_cycles++;
      cfg_we = 0;
      if (cpu_ready) begin
        r_rdata = cpu_rdata;
        break;
      end
      if (r_cycles > 40) begin
        checks++; errors++;
        $display("FAIL R7 access hung actual=%0d expected<=40", r_cycles);
        break;
      end
      if (took) begin
        fab_req_ready = 0;
        if (fab_rsp_valid) fab_rsp_valid = 0;
        else if (!r_write) begin fab_rsp_valid = 1; fab_rsp_data = rsp; end
      end else if (fab_req_valid) begin
        if (poke && !r_seen) begin cfg_we = 1; cfg_sel = 2'd0; cfg_wdata = 32'h0; end
        r_seen = 1;
        if (waited == stall) begin
          r_write = fab_req_write; r_db = fab_req_doorbell; r_dest = fab_req_dest;
          r_hop = fab_req_hop; r_ofs = fab_req_ofs; r_size = fab_req_size;
          r_wdata = fab_req_wdata;
          fab_req_ready = 1; took = 1;
        end else waited++;
      end
    end
    cpu_req = 0; fab_req_ready = 0; fab_rsp_valid = 0; cfg_we = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 cpu_ready after reset", {31'b0, cpu_ready}, 32'h0);
    check("R1 fab_req_valid after reset", {31'b0, fab_req_valid}, 32'h0);

    run_access(1'b0, 32'h8000_0000, 2'd2, 0, 32'h1, 0, 0);
    check("R1 read before enable rdata", r_rdata, 32'hFFFF_FFFF);
    check("R1 read before enable no request", {31'b0, r_seen}, 32'h0);
    check("R9 local completion latency", r_cycles, 1);

    cfg_write(2'd0, 32'hA943_CABC);
    cfg_write(2'd1, 32'h0000_0001);
    cfg_write(2'd2, 32'h5540_0000);
    cfg_write(2'd3, 32'h0000_0001);

    foreach (VECS[i]) begin
      run_access(VECS[i].we, VECS[i].addr, VECS[i].sz, VECS[i].wd, VECS[i].rsp,
                 int'(VECS[i].stall), 0);
      check($sformatf("R3 vec%0d request seen", i), {31'b0, r_seen}, 32'h1);
      check($sformatf("R3 vec%0d dest", i), {22'b0, r_dest}, 32'h2A5);
      check($sformatf("R3 vec%0d hop", i), {24'b0, r_hop}, 32'h3C);
      check($sformatf("R3 vec%0d offset", i), {11'b0, r_ofs}, {11'b0, VECS[i].ofs});
      check($sformatf("R5 vec%0d size", i), {30'b0, r_size}, {30'b0, VECS[i].esz});
      check($sformatf("R3 vec%0d write flag", i), {31'b0, r_write}, {31'b0, VECS[i].we});
      if (VECS[i].we) begin
        check($sformatf("R5 vec%0d lane data", i), r_wdata, VECS[i].ewd);
        check($sformatf("R7 vec%0d write latency", i), r_cycles, 2 + int'(VECS[i].stall));
      end else begin
        check($sformatf("R6 vec%0d read data", i), r_rdata, VECS[i].erd);
        check($sformatf("R8 vec%0d read latency", i), r_cycles, 3 + int'(VECS[i].stall));
      end
    end

    // R4: last byte of the maintenance window still translates
    run_access(1'b0, 32'h803F_FFFF, 2'd0, 0, 32'hA1B2_C3D4, 0, 0);
    check("R4 top of window request", {31'b0, r_seen}, 32'h1);
    check("R4 top of window offset", {11'b0, r_ofs}, 32'h1579FF);
    check("R6 byte lane 3", r_rdata, 32'h0000_00D4);

    // R10: doorbell send
    run_access(1'b1, 32'h8040_0010, 2'd2, 32'h9876_4321, 0, 1, 0);
    check("R10 doorbell flag", {31'b0, r_db}, 32'h1);
    check("R10 doorbell dest", {22'b0, r_dest}, 32'h155);
    check("R10 doorbell info", r_wdata, 32'h0000_4321);
    check("R10 doorbell size", {30'b0, r_size}, 32'h1);
    check("R10 doorbell hop/offset", {3'b0, r_hop, r_ofs}, 32'h0);

    // R11: doorbell read is local
    run_access(1'b0, 32'h8040_0FFE, 2'd1, 0, 32'h0, 0, 0);
    check("R11 doorbell read no request", {31'b0, r_seen}, 32'h0);
    check("R11 doorbell read data", r_rdata, 32'hFFFF_FFFF);

    // R4: outside both windows
    run_access(1'b0, 32'h8040_1000, 2'd2, 0, 32'h0, 0, 0);
    check("R4 above doorbell no request", {31'b0, r_seen}, 32'h0);
    check("R4 above doorbell data", r_rdata, 32'hFFFF_FFFF);
    run_access(1'b1, 32'h7FFF_FFFC, 2'd2, 32'h1234_5678, 0, 0, 0);
    check("R4 below window write dropped", {31'b0, r_seen}, 32'h0);

    // R12: register write during a stalled request
    run_access(1'b1, 32'h8000_0004, 2'd2, 32'h0BAD_F00D, 0, 2, 1);
    check("R12 dest kept", {22'b0, r_dest}, 32'h2A5);
    check("R12 offset kept", {11'b0, r_ofs}, 32'h157804);
    run_access(1'b1, 32'h8000_0004, 2'd2, 32'h0, 0, 0, 0);
    check("R12 new value used next", {22'b0, r_dest, r_hop[1:0]}, 32'h0);

    // R2: field boundaries, bits 21:20 ignored
    cfg_write(2'd0, 32'hFFFF_F000);
    run_access(1'b0, 32'h8000_0004, 2'd2, 0, 32'h7777_7777, 0, 0);
    check("R2 dest field", {22'b0, r_dest}, 32'h3FF);
    check("R2 hop field", {24'b0, r_hop}, 32'hFF);
    check("R2 offset field", {11'b0, r_ofs}, 32'h000004);

    // R9: disable the maintenance window
    cfg_write(2'd1, 32'h0000_0002);
    run_access(1'b1, 32'h8000_0010, 2'd2, 32'h5555_5555, 0, 0, 0);
    check("R9 disabled write dropped", {31'b0, r_seen}, 32'h0);
    run_access(1'b0, 32'h8000_0010, 2'd2, 0, 32'h0, 0, 0);
    check("R9 disabled read data", r_rdata, 32'hFFFF_FFFF);
    check("R9 disabled read no request", {31'b0, r_seen}, 32'h0);
    cfg_write(2'd3, 32'h0);
    run_access(1'b1, 32'h8040_0000, 2'd1, 32'h0000_1111, 0, 0, 0);
    check("R9 disabled doorbell dropped", {31'b0, r_seen}, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule